// File: doc/BRIEF.md
# Flyback Charger Switching Sequencer

This block is the digital sequencer of a flyback converter that charges a high-voltage capacitor from a single battery cell. It arms a charge session when the enable input rises while the supply is valid. After a fixed start delay it runs switch cycles. Each cycle turns the primary switch on, turns it off when the current limit is reached or the on-time ceiling expires, then waits for the flux-reset (valley) detector or an off-time ceiling before the next turn-on. The session ends when the output-target comparator trips during a settled part of the off-time. The block then asserts the done indicator and stops switching until enable is cycled.

All comparator and pin inputs are asynchronous and each passes through its own synchronizer. The done indicator is an open-drain enable: a high `done_pull_o` means the external pin is pulled low. A separate gate-driver output follows the flash trigger input whatever the charge state. All timer lengths are parameters in clock cycles. The defaults assume a 50 MHz clock: an 18 µs on and off ceiling, a 20 µs start delay and a 200 ns settle window.

Top module: `flyback_seq`

## Requirements
- R1: After reset, `sw_on_o`, `done_pull_o` and `gate_o` are all low.
- R2: A session arms only on a rising edge of `chg_en_i` seen while `supply_ok_i` is high. The first switch-on appears exactly START_DLY+3 cycles after `chg_en_i` rises: two synchronizer stages plus one edge register.
- R3: An enable edge seen while `supply_ok_i` is low starts nothing. If the supply later becomes valid while enable is held high, nothing starts either. Only a new low-to-high enable transition starts a session.
- R4: When `chg_en_i` goes low, `sw_on_o` is low within 3 cycles and the block returns to standby with no further switching.
- R5: A high `ilim_i` while the switch is on drives `sw_on_o` low within 3 cycles.
- R6: Without a current-limit event, the switch stays on for exactly TON_MAX cycles.
- R7: Without a valley or target event, the switch stays off for exactly TOFF_MAX cycles and then turns on again.
- R8: A high `valley_i` during off-time turns the switch on again within 3 cycles.
- R9: The target comparator is only honoured once the off-time has lasted SETTLE cycles. A target level present only earlier in the off-time is ignored. A target held high ends the session SETTLE+1 cycles after turn-off.
- R10: After a target trip, `done_pull_o` stays high and `sw_on_o` stays low for as long as enable stays high. Done and switch-on are never high together.
- R11: `done_pull_o` is low in every state other than the done state. It falls within 3 cycles of `chg_en_i` going low.
- R12: `gate_o` follows `trig_i` with a two-cycle delay in every charge state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chg_en_i | input | 1 | Charge enable, asynchronous |
| supply_ok_i | input | 1 | Supply above lockout threshold, asynchronous |
| ilim_i | input | 1 | Primary current-limit comparator, asynchronous |
| valley_i | input | 1 | Flux-reset / minimum-voltage detector, asynchronous |
| target_i | input | 1 | Output-target comparator, asynchronous |
| trig_i | input | 1 | Flash trigger request, asynchronous |
| sw_on_o | output | 1 | Primary switch gate request |
| done_pull_o | output | 1 | Pull-down enable of the open-drain done pin |
| gate_o | output | 1 | Flash gate-driver output |

## Verification
The bound checker watches, on every cycle, several properties of the switching state. It checks that the on-time never runs past its ceiling and that the off-time within a session never exceeds its ceiling. It checks that a synchronized current-limit level ends an on-phase in the next cycle and that a low enable clears both switch and done by the next cycle. It also checks that done rises only out of an off-phase with the target seen, and that done and switch-on are exclusive. Only the directed scenarios can show the arming rules: the lockout case, the need for a fresh edge, and the exact start delay. They also cover the exact ceiling lengths, the valley restart latency, the settle masking of an early target and the trigger path.

// File: rtl/flyback_pkg.sv
package flyback_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ON,
    ST_OFF,
    ST_DONE
  } seq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/flyback_sync.sv
module flyback_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES*W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[(STAGES-1)*W-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES*W-1 -: W];

endmodule

// File: rtl/flyback_ctr.sv
module flyback_ctr #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= q_o + 1'b1;
  end

endmodule

// File: rtl/flyback_fsm.sv
module flyback_fsm
  import flyback_pkg::*;
#(
  parameter int START_DLY = 1000,
  parameter int TON_MAX   = 900,
  parameter int TOFF_MAX  = 900,
  parameter int SETTLE    = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_s_i,
  input  logic ok_s_i,
  input  logic ilim_s_i,
  input  logic valley_s_i,
  input  logic target_s_i,
  output logic sw_on_o,
  output logic done_o
);

  localparam int CNT_MAX = max3(START_DLY, TON_MAX, TOFF_MAX);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(START_DLY - 1);
  localparam logic [CNT_W-1:0] ON_LAST   = CNT_W'(TON_MAX - 1);
  localparam logic [CNT_W-1:0] OFF_LAST  = CNT_W'(TOFF_MAX - 1);
  localparam logic [CNT_W-1:0] SETTLE_C  = CNT_W'(SETTLE);

  seq_state_e       state_q, state_d;
  logic             en_q;
  logic             arm;
  logic             cnt_clr, cnt_inc;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_s_i;
  end

  // fresh edge only; a level held across lockout recovery does not arm
  assign arm = en_s_i & ~en_q & ok_s_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (arm) state_d = ST_WAIT;
      ST_WAIT: if (cnt_q == WAIT_LAST) state_d = ST_ON;
      ST_ON:   if (ilim_s_i || cnt_q == ON_LAST) state_d = ST_OFF;
      ST_OFF: begin
        if (cnt_q >= SETTLE_C && target_s_i)        state_d = ST_DONE;
        else if (valley_s_i || cnt_q == OFF_LAST)   state_d = ST_ON;
      end
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
    if (!en_s_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign cnt_clr = (state_d != state_q);
  assign cnt_inc = (state_q == ST_WAIT) || (state_q == ST_ON) || (state_q == ST_OFF);

  flyback_ctr #(.W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .q_o    (cnt_q)
  );

  assign sw_on_o = (state_q == ST_ON);
  assign done_o  = (state_q == ST_DONE);

endmodule

// File: rtl/flyback_seq.sv
module flyback_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int START_DLY   = 1000,
  parameter int TON_MAX     = 900,
  parameter int TOFF_MAX    = 900,
  parameter int SETTLE      = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_en_i,
  input  logic supply_ok_i,
  input  logic ilim_i,
  input  logic valley_i,
  input  logic target_i,
  input  logic trig_i,
  output logic sw_on_o,
  output logic done_pull_o,
  output logic gate_o
);

  localparam int NIN = 6;

  logic [NIN-1:0] raw, synced;
  logic en_s, ok_s, ilim_s, valley_s, target_s, trig_s;

  assign raw = {trig_i, target_i, valley_i, ilim_i, supply_ok_i, chg_en_i};

  flyback_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (synced)
  );

  assign {trig_s, target_s, valley_s, ilim_s, ok_s, en_s} = synced;

  flyback_fsm #(
    .START_DLY (START_DLY),
    .TON_MAX   (TON_MAX),
    .TOFF_MAX  (TOFF_MAX),
    .SETTLE    (SETTLE)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_s_i     (en_s),
    .ok_s_i     (ok_s),
    .ilim_s_i   (ilim_s),
    .valley_s_i (valley_s),
    .target_s_i (target_s),
    .sw_on_o    (sw_on_o),
    .done_o     (done_pull_o)
  );

  // flash path is independent of the charge state
  assign gate_o = trig_s;

endmodule

// File: rtl/flyback_seq_chk.sv
module flyback_seq_chk #(
  parameter int TON_MAX  = 900,
  parameter int TOFF_MAX = 900
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_s,
  input logic ilim_s,
  input logic target_s,
  input logic sw_on_o,
  input logic done_pull_o
);

  int  on_run, off_run;
  logic seen_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_run  <= 0;
      off_run <= 0;
      seen_on <= 1'b0;
    end else begin
      on_run <= sw_on_o ? on_run + 1 : 0;
      if (!en_s || done_pull_o) seen_on <= 1'b0;
      else if (sw_on_o)         seen_on <= 1'b1;
      if (seen_on && en_s && !sw_on_o && !done_pull_o) off_run <= off_run + 1;
      else                                           off_run <= 0;
    end
  end

  // R6
  on_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_run <= TON_MAX);

  // R7
  off_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_run <= TOFF_MAX);

  // R5
  ilim_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_on_o && ilim_s) |=> !sw_on_o);

  // R4
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> !sw_on_o);

  // R11
  done_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> !done_pull_o);

  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_on_o && done_pull_o));

  // R10
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_pull_o && en_s) |=> done_pull_o);

  // R9
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_pull_o) |-> ($past(target_s) && !$past(sw_on_o)));

endmodule

bind flyback_seq flyback_seq_chk #(
  .TON_MAX  (TON_MAX),
  .TOFF_MAX (TOFF_MAX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_s        (en_s),
  .ilim_s      (ilim_s),
  .target_s    (target_s),
  .sw_on_o     (sw_on_o),
  .done_pull_o (done_pull_o)
);

// File: tb/sim_flyback_seq.sv
module sim_flyback_seq;

  localparam int D    = 50;
  localparam int TON  = 40;
  localparam int TOFF = 30;
  localparam int SET  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic chg_en = 0, ok = 0, ilim = 0, valley = 0, target = 0, trig = 0;
  logic sw_on, done_pull, gate;

  int checks = 0;
  int errors = 0;

  flyback_seq #(
    .SYNC_STAGES (2),
    .START_DLY   (D),
    .TON_MAX     (TON),
    .TOFF_MAX    (TOFF),
    .SETTLE      (SET)
  ) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .chg_en_i    (chg_en),
    .supply_ok_i (ok),
    .ilim_i      (ilim),
    .valley_i    (valley),
    .target_i    (target),
    .trig_i      (trig),
    .sw_on_o     (sw_on),
    .done_pull_o (done_pull),
    .gate_o      (gate)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_sw(input logic val, input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sw_on !== val && n < lim);
  endtask

  task automatic wait_done(input logic val, input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (done_pull !== val && n < lim);
  endtask

  task automatic observe(input int n, output int sw_hits, output int done_hits);
    sw_hits = 0;
    done_hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sw_on === 1'b1)     sw_hits++;
      if (done_pull === 1'b1) done_hits++;
    end
  endtask

  task automatic t_reset;
    chk("R1 sw_on after reset", sw_on, 0);
    chk("R1 done after reset", done_pull, 0);
    chk("R1 gate after reset", gate, 0);
  endtask

  task automatic t_start_timing;
    int n;
    ok = 1;
    cyc(5);
    chg_en = 1;
    wait_sw(1, D + 20, n);
    chk("R2 start delay", n, D + 3);
    wait_sw(0, TON + 10, n);
    chk("R6 on-time ceiling", n, TON);
    wait_sw(1, TOFF + 10, n);
    chk("R7 off-time ceiling", n, TOFF);
  endtask

  task automatic t_ilim;
    int n;
    cyc(5);
    ilim = 1;
    wait_sw(0, 10, n);
    chk("R5 current-limit turn-off", n, 3);
    ilim = 0;
  endtask

  task automatic t_valley;
    int n;
    cyc(5);
    valley = 1;
    wait_sw(1, 10, n);
    chk("R8 valley restart", n, 3);
    valley = 0;
  endtask

  task automatic t_settle_mask;
    int n, s, d;
    target = 1;
    wait_sw(0, TON + 10, n);
    target = 0;
    observe(20, s, d);
    chk("R9 early target ignored", d, 0);
    chk("R11 done low while switching", d, 0);
  endtask

  task automatic t_trip;
    int n, s, d;
    wait_sw(1, TOFF + 10, n);
    target = 1;
    wait_sw(0, TON + 10, n);
    wait_done(1, SET + 10, n);
    chk("R9 trip after settle", n, SET + 1);
    observe(100, s, d);
    chk("R10 no switching after trip", s, 0);
    chk("R10 done held", d, 100);
    chg_en = 0;
    wait_done(0, 10, n);
    chk("R11 done release on enable low", n, 3);
    target = 0;
    cyc(5);
  endtask

  task automatic t_stop;
    int n, s, d;
    chg_en = 1;
    wait_sw(1, D + 20, n);
    chk("R2 restart after new edge", n, D + 3);
    cyc(4);
    chg_en = 0;
    wait_sw(0, 10, n);
    chk("R4 stop latency", n, 3);
    observe(60, s, d);
    chk("R4 standby no switching", s, 0);
    chk("R11 done low in standby", d, 0);
  endtask

  task automatic t_lockout;
    int n, s, d;
    ok = 0;
    cyc(5);
    chg_en = 1;
    observe(D + 40, s, d);
    chk("R3 edge during lockout", s, 0);
    ok = 1;
    observe(D + 40, s, d);
    chk("R3 supply recovery without edge", s, 0);
    chg_en = 0;
    cyc(5);
    chg_en = 1;
    wait_sw(1, D + 20, n);
    chk("R3 fresh edge starts", n, D + 3);
    chg_en = 0;
    cyc(5);
  endtask

  task automatic t_gate;
    int n;
    trig = 1;
    cyc(1);
    chk("R12 gate latency idle, cycle 1", gate, 0);
    cyc(1);
    chk("R12 gate high idle", gate, 1);
    trig = 0;
    cyc(2);
    chk("R12 gate low idle", gate, 0);
    chg_en = 1;
    wait_sw(1, D + 20, n);
    trig = 1;
    cyc(2);
    chk("R12 gate high while charging", gate, 1);
    trig = 0;
    cyc(2);
    chk("R12 gate low while charging", gate, 0);
    chg_en = 0;
    cyc(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    t_reset();
    t_start_timing();
    t_ilim();
    t_valley();
    t_settle_mask();
    t_trip();
    t_stop();
    t_lockout();
    t_gate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule